// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Process Tags

This block caches translations from virtual page numbers to physical frame numbers. Any translation can sit in any slot. A lookup compares the key against every stored slot at the same time. Each slot carries a process tag, so translations that belong to different processes can stay resident across a context switch. A slot can also be marked global, which makes it match under every process tag.

A lookup presents a page number, the current process tag and a read/write flag. One clock later the block returns one of three results: a hit, a miss, or a protection refusal, together with the frame number. On a miss, a page-table walker or a software handler supplies the translation through the fill port. Stale translations are removed in one of three ways: by page and process tag, by process tag alone, or all at once.

Top module: `tlb_fa`

## Requirements
- R1: While `rst_n` is low, every slot becomes invalid, the round-robin pointer returns to slot 0, and all response outputs are 0. Any lookup made after reset, and before the first fill, misses.
- R2: The response is registered. `rsp_valid` is high in the cycle after a cycle with `lk_en` high, and exactly one of `rsp_hit`, `rsp_miss` and `rsp_prot` is high with it. A slot matches when it is valid, its page number equals `lk_vpn`, and either its tag equals `lk_asid` or it is global. `rsp_pfn` returns the frame number of the matching slot. `rsp_pfn` is 0 on a miss and 0 when `rsp_valid` is low.
- R3: A non-global slot whose process tag differs from `lk_asid` does not match, and the lookup reports `rsp_miss`.
- R4: A write lookup (`lk_write`=1) that matches a slot whose write-permit bit is 0 gives `rsp_prot`=1, `rsp_hit`=0, `rsp_miss`=0, with the slot's frame number on `rsp_pfn`. A read lookup that matches the same slot hits.
- R5: Each slot has a reference bit. A fill clears it and a successful hit sets it. `rsp_ref` returns the bit's value before this hit, and is 0 unless `rsp_hit` is 1.
- R6: A fill whose page number equals that of a valid slot, and whose tags match (equal tags, or either side global), overwrites the lowest-numbered such slot. Every other such slot is dropped, so no lookup ever matches two slots.
- R7: A fill with no such matching slot goes to the lowest-numbered invalid slot, and the round-robin pointer does not move.
- R8: When every slot is valid and there is no matching slot, a fill replaces the slot named by the round-robin pointer. The pointer then advances by one, wrapping from ENTRIES-1 to 0.
- R9: A single invalidate (`inv_en`) removes the slots that a lookup with `inv_vpn`/`inv_asid` would match, including global ones.
- R10: A tag flush (`flush_asid_en`) removes every non-global slot whose tag equals `flush_asid_id` and keeps global slots. A full flush (`flush_all`) removes every slot.
- R11: In one cycle only the highest-priority update takes effect: `flush_all` first, then `flush_asid_en`, then `inv_en`, then `fill_en`. A lookup in the same cycle sees the table as it was before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_en | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Current process tag |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No matching slot |
| rsp_prot | output | 1 | Write refused by the permit bit |
| rsp_ref | output | 1 | Reference bit before this hit |
| rsp_pfn | output | PFN_W | Physical frame number |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VPN_W | Fill page number |
| fill_asid | input | ASID_W | Fill process tag |
| fill_pfn | input | PFN_W | Fill frame number |
| fill_wr | input | 1 | Fill write-permit bit |
| fill_global | input | 1 | Fill matches under any tag |
| inv_en | input | 1 | Single-translation invalidate |
| inv_vpn | input | VPN_W | Invalidate page number |
| inv_asid | input | ASID_W | Invalidate process tag |
| flush_asid_en | input | 1 | Flush one process tag |
| flush_asid_id | input | ASID_W | Tag to flush |
| flush_all | input | 1 | Flush every slot |

## Verification
The bench builds the block with ENTRIES=8, VPN_W=12, PFN_W=16 and ASID_W=6, keeping the global option on. With eight slots, filling the table, wrapping the round-robin pointer and mixing freed slots with full-table evictions all happen within a few dozen fills. The 6-bit tag stays at its full width, so tag compare and tag flush see real encodings. The narrow page range used in the random phase makes repeated fills of the same page, global/tag overlaps and protection refusals frequent.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // One table update per cycle, already resolved by priority.
   typedef enum logic [2:0] {
      OP_NONE       = 3'd0,
      OP_FLUSH_ALL  = 3'd1,
      OP_FLUSH_ASID = 3'd2,
      OP_INV        = 3'd3,
      OP_FILL       = 3'd4
   } tlb_op_e;

endpackage

// File: rtl/tlb_first_one.sv
// Lowest-index set bit of a vector.
module tlb_first_one #(
   parameter int N     = 8,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/tlb_cam.sv
// Parallel tag compare across all slots.
module tlb_cam #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int ASID_W  = 6
) (
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] glob_vec,
   input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
   input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
   input  logic [VPN_W-1:0]   key_vpn,
   input  logic [ASID_W-1:0]  key_asid,
   input  logic               key_any,
   output logic [ENTRIES-1:0] match_vec
);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = valid_vec[g]
                         && (ent_vpn[g] == key_vpn)
                         && ((ent_asid[g] == key_asid) || glob_vec[g] || key_any);
   end

endmodule

// File: rtl/tlb_victim.sv
// Fill slot choice: existing match, else first free, else round robin.
module tlb_victim #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic [ENTRIES-1:0] dup_vec,
   input  logic               take,
   output logic [IDX_W-1:0]   vic_idx,
   output logic               rr_take,
   output logic [IDX_W-1:0]   rr_ptr
);

   logic             dup_found, free_found;
   logic [IDX_W-1:0] dup_idx, free_idx;

   tlb_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_dup (
      .vec(dup_vec), .found(dup_found), .idx(dup_idx)
   );

   tlb_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
      .vec(~valid_vec), .found(free_found), .idx(free_idx)
   );

   always_comb begin
      if (dup_found)       vic_idx = dup_idx;
      else if (free_found) vic_idx = free_idx;
      else                 vic_idx = rr_ptr;
   end

   assign rr_take = take && !dup_found && !free_found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_ptr <= '0;
      end else if (rr_take) begin
         rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
      end
   end

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
   import tlb_pkg::*;
#(
   parameter int ENTRIES    = 64,
   parameter int VPN_W      = 20,
   parameter int PFN_W      = 20,
   parameter int ASID_W     = 6,
   parameter bit HAS_GLOBAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_en,
   input  logic              lk_write,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_prot,
   output logic              rsp_ref,
   output logic [PFN_W-1:0]  rsp_pfn,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic              fill_wr,
   input  logic              fill_global,
   input  logic              inv_en,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [ASID_W-1:0] inv_asid,
   input  logic              flush_asid_en,
   input  logic [ASID_W-1:0] flush_asid_id,
   input  logic              flush_all
);

   localparam int IDX_W = $clog2(ENTRIES);

   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_fa: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("tlb_fa: field widths must be positive");
   end

   // slot state
   logic [ENTRIES-1:0] valid_q, wr_q, glob_q, ref_q;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [ASID_W-1:0]  asid_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q  [ENTRIES];

   // global option: variant chosen by parameter
   logic glob_d;
   if (HAS_GLOBAL) begin : g_glob
      assign glob_d = fill_global;
   end else begin : g_noglob
      assign glob_d = 1'b0;
   end

   // lookup path
   logic [ENTRIES-1:0] lk_match;
   logic               lk_found, lk_ok;
   logic [IDX_W-1:0]   lk_idx;

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lk (
      .valid_vec(valid_q), .glob_vec(glob_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
      .key_vpn(lk_vpn), .key_asid(lk_asid), .key_any(1'b0), .match_vec(lk_match)
   );

   tlb_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_sel (
      .vec(lk_match), .found(lk_found), .idx(lk_idx)
   );

   assign lk_ok = lk_found && (!lk_write || wr_q[lk_idx]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_prot  <= 1'b0;
         rsp_ref   <= 1'b0;
         rsp_pfn   <= '0;
      end else begin
         rsp_valid <= lk_en;
         rsp_hit   <= lk_en && lk_ok;
         rsp_miss  <= lk_en && !lk_found;
         rsp_prot  <= lk_en && lk_found && !lk_ok;
         rsp_ref   <= lk_en && lk_ok && ref_q[lk_idx];
         rsp_pfn   <= (lk_en && lk_found) ? pfn_q[lk_idx] : '0;
      end
   end

   // update path
   tlb_op_e op;
   always_comb begin
      if (flush_all)          op = OP_FLUSH_ALL;
      else if (flush_asid_en) op = OP_FLUSH_ASID;
      else if (inv_en)        op = OP_INV;
      else if (fill_en)       op = OP_FILL;
      else                    op = OP_NONE;
   end

   logic [ENTRIES-1:0] fill_match, inv_match, asid_kill;

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_fill (
      .valid_vec(valid_q), .glob_vec(glob_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
      .key_vpn(fill_vpn), .key_asid(fill_asid), .key_any(glob_d), .match_vec(fill_match)
   );

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_inv (
      .valid_vec(valid_q), .glob_vec(glob_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
      .key_vpn(inv_vpn), .key_asid(inv_asid), .key_any(1'b0), .match_vec(inv_match)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
      assign asid_kill[g] = (asid_q[g] == flush_asid_id) && !glob_q[g];
   end

   logic [IDX_W-1:0] vic_idx, rr_ptr;
   logic             rr_take;

   tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
      .clk(clk), .rst_n(rst_n), .valid_vec(valid_q), .dup_vec(fill_match),
      .take(op == OP_FILL), .vic_idx(vic_idx), .rr_take(rr_take), .rr_ptr(rr_ptr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         wr_q    <= '0;
         glob_q  <= '0;
         ref_q   <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            vpn_q[i]  <= '0;
            asid_q[i] <= '0;
            pfn_q[i]  <= '0;
         end
      end else begin
         if (lk_en && lk_ok) ref_q[lk_idx] <= 1'b1;
         unique case (op)
            OP_FLUSH_ALL:  valid_q <= '0;
            OP_FLUSH_ASID: valid_q <= valid_q & ~asid_kill;
            OP_INV:        valid_q <= valid_q & ~inv_match;
            OP_FILL: begin
               valid_q         <= (valid_q & ~fill_match) | (ENTRIES'(1) << vic_idx);
               wr_q[vic_idx]   <= fill_wr;
               glob_q[vic_idx] <= glob_d;
               ref_q[vic_idx]  <= 1'b0;
               vpn_q[vic_idx]  <= fill_vpn;
               asid_q[vic_idx] <= fill_asid;
               pfn_q[vic_idx]  <= fill_pfn;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_en,
   input logic               lk_write,
   input logic               rsp_valid,
   input logic               rsp_hit,
   input logic               rsp_miss,
   input logic               rsp_prot,
   input logic               rsp_ref,
   input logic [ENTRIES-1:0] match_vec,
   input logic [ENTRIES-1:0] valid_vec,
   input logic               flush_all,
   input logic               rr_take,
   input logic [IDX_W-1:0]   rr_ptr
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_prot || rsp_ref)); // R1

   AST_RSP_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_prot}) == 1); // R2

   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_en |=> rsp_valid); // R2

   AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_en |=> !rsp_valid); // R2

   AST_PROT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_prot |-> $past(lk_write)); // R4

   AST_REF_ONLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ref |-> rsp_hit); // R5

   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec)); // R6

   AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rr_take |=> int'(rr_ptr) == ((int'($past(rr_ptr)) + 1) % ENTRIES)); // R8

   AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rr_take |=> $stable(rr_ptr)); // R7

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> valid_vec == '0); // R10

endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_write(lk_write),
   .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
   .rsp_prot(rsp_prot), .rsp_ref(rsp_ref), .match_vec(lk_match),
   .valid_vec(valid_q), .flush_all(flush_all), .rr_take(rr_take), .rr_ptr(rr_ptr)
);

// File: tb/tlb_fa_bench.sv
`timescale 1ns/1ps
module tlb_fa_bench;

   localparam int E  = 8;
   localparam int VW = 12;
   localparam int PW = 16;
   localparam int AW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic          lk_en = 0, lk_write = 0;
   logic [VW-1:0] lk_vpn = '0;
   logic [AW-1:0] lk_asid = '0;
   logic          rsp_valid, rsp_hit, rsp_miss, rsp_prot, rsp_ref;
   logic [PW-1:0] rsp_pfn;
   logic          fill_en = 0, fill_wr = 0, fill_global = 0;
   logic [VW-1:0] fill_vpn = '0;
   logic [AW-1:0] fill_asid = '0;
   logic [PW-1:0] fill_pfn = '0;
   logic          inv_en = 0;
   logic [VW-1:0] inv_vpn = '0;
   logic [AW-1:0] inv_asid = '0;
   logic          flush_asid_en = 0, flush_all = 0;
   logic [AW-1:0] flush_asid_id = '0;

   tlb_fa #(.ENTRIES(E), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW), .HAS_GLOBAL(1'b1)) u_tlb_fa (
      .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .lk_write(lk_write), .lk_vpn(lk_vpn),
      .lk_asid(lk_asid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_prot(rsp_prot), .rsp_ref(rsp_ref), .rsp_pfn(rsp_pfn), .fill_en(fill_en),
      .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn), .fill_wr(fill_wr),
      .fill_global(fill_global), .inv_en(inv_en), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
      .flush_asid_en(flush_asid_en), .flush_asid_id(flush_asid_id), .flush_all(flush_all)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit          m_v [E], m_w [E], m_g [E], m_r [E];
   int          m_vpn [E], m_asid [E], m_pfn [E];
   int          m_rr = 0;
   bit          e_valid = 0, e_hit = 0, e_miss = 0, e_prot = 0, e_ref = 0;
   int          e_pfn = 0;

   always @(posedge clk) begin
      int mi, dup, free, slot;
      if (!rst_n) begin
         for (int i = 0; i < E; i++) begin
            m_v[i] = 0; m_w[i] = 0; m_g[i] = 0; m_r[i] = 0;
         end
         m_rr = 0;
         e_valid = 0; e_hit = 0; e_miss = 0; e_prot = 0; e_ref = 0; e_pfn = 0;
      end else begin
         mi = -1;
         for (int i = 0; i < E; i++)
            if (mi < 0 && m_v[i] && m_vpn[i] == int'(lk_vpn) &&
                (m_asid[i] == int'(lk_asid) || m_g[i])) mi = i;
         e_valid = lk_en; e_hit = 0; e_miss = 0; e_prot = 0; e_ref = 0; e_pfn = 0;
         if (lk_en) begin
            if (mi < 0) e_miss = 1;
            else begin
               e_pfn = m_pfn[mi];
               if (lk_write && !m_w[mi]) e_prot = 1;
               else begin
                  e_hit = 1; e_ref = m_r[mi]; m_r[mi] = 1;
               end
            end
         end
         if (flush_all) begin
            for (int i = 0; i < E; i++) m_v[i] = 0;
         end else if (flush_asid_en) begin
            for (int i = 0; i < E; i++)
               if (m_asid[i] == int'(flush_asid_id) && !m_g[i]) m_v[i] = 0;
         end else if (inv_en) begin
            for (int i = 0; i < E; i++)
               if (m_v[i] && m_vpn[i] == int'(inv_vpn) &&
                   (m_asid[i] == int'(inv_asid) || m_g[i])) m_v[i] = 0;
         end else if (fill_en) begin
            free = -1; dup = -1;
            for (int i = 0; i < E; i++) if (free < 0 && !m_v[i]) free = i;
            for (int i = 0; i < E; i++)
               if (m_v[i] && m_vpn[i] == int'(fill_vpn) &&
                   (m_asid[i] == int'(fill_asid) || m_g[i] || fill_global)) begin
                  if (dup < 0) dup = i;
                  m_v[i] = 0;
               end
            if (dup >= 0) slot = dup;
            else if (free >= 0) slot = free;
            else begin
               slot = m_rr; m_rr = (m_rr + 1) % E;
            end
            m_v[slot] = 1; m_w[slot] = fill_wr; m_g[slot] = fill_global; m_r[slot] = 0;
            m_vpn[slot] = int'(fill_vpn); m_asid[slot] = int'(fill_asid);
            m_pfn[slot] = int'(fill_pfn);
         end
      end
   end

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      chk(rsp_valid == e_valid, "R2", "rsp_valid", rsp_valid, e_valid);
      chk(rsp_hit == e_hit && rsp_miss == e_miss, "R3", "hit/miss",
          {rsp_hit, rsp_miss}, {e_hit, e_miss});
      chk(rsp_prot == e_prot, "R4", "rsp_prot", rsp_prot, e_prot);
      chk(rsp_ref == e_ref, "R5", "rsp_ref", rsp_ref, e_ref);
      chk(int'(rsp_pfn) == e_pfn, "R2", "rsp_pfn", rsp_pfn, e_pfn);
   end

   // ---------------- directed helpers ----------------
   task automatic do_fill(input int vpn, input int asid, input int pfn,
                          input bit wr, input bit glob);
      fill_en = 1; fill_vpn = VW'(vpn); fill_asid = AW'(asid);
      fill_pfn = PW'(pfn); fill_wr = wr; fill_global = glob;
      @(negedge clk);
      fill_en = 0; fill_global = 0;
   endtask

   task automatic do_look(input int vpn, input int asid, input bit wr);
      lk_en = 1; lk_vpn = VW'(vpn); lk_asid = AW'(asid); lk_write = wr;
      @(negedge clk);
      lk_en = 0; lk_write = 0;
   endtask

   task automatic exp_hit(input int vpn, input int asid, input int pfn, input string tag);
      do_look(vpn, asid, 0);
      chk(rsp_hit == 1'b1, tag, "hit", rsp_hit, 1);
      chk(int'(rsp_pfn) == pfn, tag, "pfn", rsp_pfn, pfn);
   endtask

   task automatic exp_miss(input int vpn, input int asid, input string tag);
      do_look(vpn, asid, 0);
      chk(rsp_miss == 1'b1 && rsp_hit == 1'b0, tag, "miss", rsp_miss, 1);
   endtask

   task automatic do_inv(input int vpn, input int asid);
      inv_en = 1; inv_vpn = VW'(vpn); inv_asid = AW'(asid);
      @(negedge clk);
      inv_en = 0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet in reset
      chk(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_prot && rsp_pfn == '0,
          "R1", "reset outputs", {rsp_valid, rsp_hit, rsp_miss, rsp_prot}, 0);
      rst_n = 1;
      @(negedge clk);
      exp_miss(5, 1, "R1");

      // R2 / R5
      do_fill('h10, 3, 'hA10, 1, 0);
      exp_hit('h10, 3, 'hA10, "R2");
      chk(rsp_ref == 1'b0, "R5", "ref first use", rsp_ref, 0);
      do_look('h10, 3, 0);
      chk(rsp_ref == 1'b1, "R5", "ref second use", rsp_ref, 1);
      // R3
      exp_miss('h10, 4, "R3");
      // R4
      do_fill('h20, 3, 'hB20, 0, 0);
      exp_hit('h20, 3, 'hB20, "R4");
      do_look('h20, 3, 1);
      chk(rsp_prot == 1'b1 && rsp_hit == 1'b0 && rsp_miss == 1'b0, "R4", "prot",
          {rsp_prot, rsp_hit, rsp_miss}, 3'b100);
      chk(int'(rsp_pfn) == 'hB20, "R4", "prot pfn", rsp_pfn, 'hB20);
      // global slot
      do_fill('h30, 7, 'hC30, 1, 1);
      exp_hit('h30, 9, 'hC30, "R2");
      // R6 overwrite
      do_fill('h10, 3, 'hD10, 1, 0);
      exp_hit('h10, 3, 'hD10, "R6");
      chk(rsp_ref == 1'b0, "R5", "fill clears ref", rsp_ref, 0);
      // R9 then R6: no stale copy left
      do_inv('h10, 3);
      exp_miss('h10, 3, "R9");
      // fill table: slot 0 free, then slots 3..7
      for (int k = 0; k < 6; k++) do_fill('h40 + k, 3, 'h140 + k, 1, 0);
      // R8 full table: round robin from slot 0
      do_fill('h50, 3, 'h150, 1, 0);
      exp_miss('h40, 3, "R8");
      exp_hit('h41, 3, 'h141, "R8");
      do_fill('h51, 3, 'h151, 1, 0);
      exp_miss('h20, 3, "R8");
      exp_hit('h30, 3, 'hC30, "R8");
      // R7 freed slot taken before round robin (pointer at the global slot)
      do_inv('h43, 3);
      do_fill('h60, 3, 'h160, 1, 0);
      exp_hit('h30, 3, 'hC30, "R7");
      exp_hit('h60, 3, 'h160, "R7");
      // R10 tag flush keeps global
      flush_asid_en = 1; flush_asid_id = AW'(3);
      @(negedge clk);
      flush_asid_en = 0;
      exp_hit('h30, 3, 'hC30, "R10");
      exp_miss('h44, 3, "R10");
      flush_all = 1;
      @(negedge clk);
      flush_all = 0;
      exp_miss('h30, 3, "R10");
      // R11 priority: invalidate beats fill
      inv_en = 1; inv_vpn = VW'('h70); inv_asid = AW'(3);
      do_fill('h70, 3, 'h170, 1, 0);
      inv_en = 0;
      exp_miss('h70, 3, "R11");
      // R11 lookup sees the old table
      lk_en = 1; lk_vpn = VW'('h71); lk_asid = AW'(3);
      do_fill('h71, 3, 'h171, 1, 0);
      lk_en = 0;
      chk(rsp_miss == 1'b1, "R11", "lookup before fill", rsp_miss, 1);
      exp_hit('h71, 3, 'h171, "R11");
      flush_all = 1;
      do_fill('h72, 3, 'h172, 1, 0);
      flush_all = 0;
      exp_miss('h72, 3, "R11");
      // R9 invalidate removes a global slot under another tag
      do_fill('h30, 7, 'hC30, 1, 1);
      do_inv('h30, 1);
      exp_miss('h30, 7, "R9");

      // random phase, checked by the model every cycle
      for (int n = 0; n < 4000; n++) begin
         lk_en = ($urandom % 4) != 0;
         lk_write = $urandom % 2;
         lk_vpn = VW'($urandom % 16);
         lk_asid = AW'($urandom % 4);
         fill_en = ($urandom % 3) == 0;
         fill_vpn = VW'($urandom % 16);
         fill_asid = AW'($urandom % 4);
         fill_pfn = PW'($urandom);
         fill_wr = ($urandom % 4) != 0;
         fill_global = ($urandom % 8) == 0;
         inv_en = ($urandom % 10) == 0;
         inv_vpn = VW'($urandom % 16);
         inv_asid = AW'($urandom % 4);
         flush_asid_en = ($urandom % 40) == 0;
         flush_asid_id = AW'($urandom % 4);
         flush_all = ($urandom % 150) == 0;
         @(negedge clk);
      end
      lk_en = 0; fill_en = 0; inv_en = 0; flush_asid_en = 0; flush_all = 0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule